// File: doc/BRIEF.md
# ADC Two-Point Calibration Corrector

This block turns a raw 12-bit converter code into a reading in millivolts for one of sixteen input channels. Each calibrated channel has a pair of ideal codes (2064 and 3112) and two expected voltages at those codes. Two factory trim values per channel describe how far the real converter is from the ideal one.

A calibration request carries a channel index and its two signed trim values. The block derives a gain-error factor, a gain and an offset from them and stores all three for that channel. A conversion request carries a channel index and a raw code. The block returns the corrected value together with two flags: one for a calibration mismatch and one for a channel that has not been calibrated yet.

All division goes through one shared radix-2 restoring divider. The divider truncates toward zero and takes a fixed number of cycles per quotient. While an operation is in flight, `busy` is high and new requests are not accepted.

Top module: `adc_cal_corrector`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `out_valid` and `cal_done` are low and no channel counts as calibrated.
- R2: A calibration of channel c with signed 8-bit trims d1 (`cal_lo_trim`) and d2 (`cal_hi_trim`) stores the following, with every division truncating toward zero:
  - k = 1000 + 1000·(d2−d1)/1048
  - gain = (v2−v1)·1000/1048
  - offset = d1·1000 − (k−1000)·2064

  The expected voltages (v1, v2) are:
  - 630/950 for channels 0, 1, 3, 4 and 5
  - 1260/1900 for channel 2
  - 2520/3800 for channels 6 and 7
  - 3150/4750 for channel 8
  - 5670/8550 for channel 9
  - 3465/5225 for channel 10
  - 3645/5225 for channel 14

  A later calibration of the same channel replaces the earlier values.
- R3: A conversion on a calibrated channel computes i = (raw·1000 − offset)/k. When i ≥ 0 it returns i·gain/1000 with both flags low.
- R4: When i < 0, the output is 0 and `out_mismatch` is 1.
- R5: Channels 11, 12, 13 and 15 need no calibration. They return raw·UNCAL_GAIN/1000 (UNCAL_GAIN defaults to 1000, so the raw code comes back unchanged). A calibration request on one of them stores nothing and pulses `cal_done` right after the accepting edge.
- R6: A conversion on any other channel before its first calibration returns the raw code with `out_not_cal` = 1. The result appears right after the accepting edge and `busy` never rises.
- R7: Requests are accepted only while `busy` is low. If both request inputs are high together, calibration wins and the conversion request is dropped. `busy` is high from the accepting edge until the edge that raises `out_valid` or `cal_done`. Each of those two outputs is a one-cycle pulse.
- R8: Requests presented while `busy` is high are ignored. They produce no extra result and do not change stored coefficients.
- R9: Counting the accepting edge as edge 1, results are visible after these edges:
  - a divider-free result: edge 1
  - a single-division result (mismatch, or channels 11/12/13/15): edge DW+2
  - a two-division result (calibration, or a full correction): edge 2·DW+3
- R10: Negative intermediate quotients truncate toward zero. For example, d1=5 and d2=−3 give k=993, not 992.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_valid | input | 1 | Calibration request |
| cal_ch | input | 4 | Channel to calibrate |
| cal_lo_trim | input | 8 | Signed trim d1 |
| cal_hi_trim | input | 8 | Signed trim d2 |
| cal_done | output | 1 | Calibration finished (one-cycle pulse) |
| conv_valid | input | 1 | Conversion request |
| conv_ch | input | 4 | Channel of the raw code |
| conv_raw | input | 12 | Raw converter code |
| busy | output | 1 | Operation in flight; requests are ignored |
| out_valid | output | 1 | Result valid (one-cycle pulse) |
| out_mv | output | 32 | Signed result in millivolts |
| out_mismatch | output | 1 | Intermediate code was negative; result forced to 0 |
| out_not_cal | output | 1 | Channel not yet calibrated; raw code returned |

## Verification
Every result is due a fixed number of edges after the accepting edge:
- one edge for the uncalibrated-channel error path and for a calibration on channels 11, 12, 13 or 15
- DW+2 edges for a mismatch or a fixed-scale channel
- 2·DW+3 edges for calibration and full correction

The bench drives requests at falling edges and then counts rising edges until the result appears, sampling at each following falling edge. It compares the count with the expected value for that path, so a result that arrives early or late fails just as a wrong value does. After a burst of requests injected mid-operation, the bench keeps watching for a window longer than the longest path to confirm that no stray pulse appears.

// File: rtl/adc_cal_pkg.sv
`timescale 1ns/1ps
// Shared constants, state type and per-channel calibration data.
// Assumes sixteen channels; indices outside the table read as uncalibrated-free zeros.
package adc_cal_pkg;

    localparam int IDEAL_LO  = 2064;   // ideal code at the lower calibration point
    localparam int IDEAL_HI  = 3112;   // ideal code at the upper calibration point
    localparam int MILLI     = 1000;   // fixed-point scale of gain and gain error

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GERR,
        ST_GAIN,
        ST_INTER,
        ST_SCALE
    } cal_state_t;

    // Channels with no trim data: no offset or gain-error correction.
    function automatic logic chan_uncal(input int ch);
        return (ch == 11) || (ch == 12) || (ch == 13) || (ch == 15);
    endfunction

    // Expected millivolts at the lower ideal code.
    function automatic int chan_v_lo(input int ch);
        case (ch)
            0, 1, 3, 4, 5: return 630;
            2:             return 1260;
            6, 7:          return 2520;
            8:             return 3150;
            9:             return 5670;
            10:            return 3465;
            14:            return 3645;
            default:       return 0;
        endcase
    endfunction

    // Expected millivolts at the upper ideal code.
    function automatic int chan_v_hi(input int ch);
        case (ch)
            0, 1, 3, 4, 5: return 950;
            2:             return 1900;
            6, 7:          return 3800;
            8:             return 4750;
            9:             return 8550;
            10, 14:        return 5225;
            default:       return 0;
        endcase
    endfunction

endpackage

// File: rtl/adc_seq_div.sv
`timescale 1ns/1ps
// Signed radix-2 restoring divider.
// One quotient bit per cycle, DW cycles after start; the quotient truncates toward zero.
// Assumes den is nonzero and start is raised only while running is low.
module adc_seq_div #(
    parameter int DW = 32,
    localparam int CW = $clog2(DW + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic signed [DW-1:0] num,
    input  logic signed [DW-1:0] den,
    output logic                 running,
    output logic                 done,
    output logic signed [DW-1:0] quo
);

    logic [DW-1:0] q_sh;
    logic [DW-1:0] rem;
    logic [DW-1:0] d_mag;
    logic          neg;
    logic [CW-1:0] cnt;
    logic [DW:0]   trial;
    logic          fits;
    logic [DW-1:0] rem_nx;
    logic [DW-1:0] q_nx;

    // One restoring step: shift in the next dividend bit, subtract if it fits.
    always_comb begin
        trial  = {rem, q_sh[DW-1]};
        fits   = trial >= {1'b0, d_mag};
        rem_nx = fits ? DW'(trial - {1'b0, d_mag}) : trial[DW-1:0];
        q_nx   = {q_sh[DW-2:0], fits};
    end

    // Load operand magnitudes on start, iterate, apply the sign on the last step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            done    <= 1'b0;
            cnt     <= '0;
            q_sh    <= '0;
            rem     <= '0;
            d_mag   <= '0;
            neg     <= 1'b0;
            quo     <= '0;
        end else begin
            done <= 1'b0;
            if (start && !running) begin
                running <= 1'b1;
                cnt     <= CW'(DW);
                q_sh    <= num[DW-1] ? -num : num;
                d_mag   <= den[DW-1] ? -den : den;
                rem     <= '0;
                neg     <= num[DW-1] ^ den[DW-1];
            end else if (running) begin
                rem  <= rem_nx;
                q_sh <= q_nx;
                cnt  <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    running <= 1'b0;
                    done    <= 1'b1;
                    quo     <= neg ? -signed'(q_nx) : signed'(q_nx);
                end
            end
        end
    end

    // R9: the controller never restarts a division in flight
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !running);
    // R9: done is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: never divide by zero
    a_r9_den_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> den != '0);

endmodule

// File: rtl/adc_cal_store.sv
`timescale 1ns/1ps
// Per-channel coefficient storage: gain error, gain, offset and a calibrated bit.
// Coefficient words are not reset; they are meaningful only when the calibrated bit is set.
module adc_cal_store #(
    parameter int NCH  = 16,
    parameter int DW   = 32,
    parameter int CH_W = $clog2(NCH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [CH_W-1:0]      wr_ch,
    input  logic signed [DW-1:0] wr_k,
    input  logic signed [DW-1:0] wr_gain,
    input  logic signed [DW-1:0] wr_off,
    input  logic [CH_W-1:0]      rd_ch,
    output logic signed [DW-1:0] rd_k,
    output logic signed [DW-1:0] rd_gain,
    output logic signed [DW-1:0] rd_off,
    output logic                 rd_ok,
    output logic                 rd_uncal
);

    logic [NCH-1:0]       ok_q;
    logic [NCH-1:0]       uncal_mask;
    logic signed [DW-1:0] k_mem    [NCH];
    logic signed [DW-1:0] gain_mem [NCH];
    logic signed [DW-1:0] off_mem  [NCH];

    // Fixed mask of channels that carry no trim data.
    for (genvar i = 0; i < NCH; i++) begin : g_mask
        assign uncal_mask[i] = adc_cal_pkg::chan_uncal(i);
    end

    // Calibrated flags: cleared by reset, set by a coefficient write.
    always_ff @(posedge clk) begin
        if (!rst_n) ok_q <= '0;
        else if (we) ok_q[wr_ch] <= 1'b1;
    end

    // Coefficient words for the channel being written.
    always_ff @(posedge clk) begin
        if (we) begin
            k_mem[wr_ch]    <= wr_k;
            gain_mem[wr_ch] <= wr_gain;
            off_mem[wr_ch]  <= wr_off;
        end
    end

    assign rd_k     = k_mem[rd_ch];
    assign rd_gain  = gain_mem[rd_ch];
    assign rd_off   = off_mem[rd_ch];
    assign rd_ok    = ok_q[rd_ch];
    assign rd_uncal = uncal_mask[rd_ch];

    // R5: channels without trim data never receive coefficients
    a_r5_no_uncal_write: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> !uncal_mask[wr_ch]);

endmodule

// File: rtl/adc_cal_corrector.sv
`timescale 1ns/1ps
// Two-point calibration corrector: derives per-channel coefficients from trims and
// converts raw codes to millivolts with one shared sequential divider.
// Assumes callers hold requests only while busy is low; requests seen while busy are dropped.
module adc_cal_corrector #(
    parameter int NCH        = 16,
    parameter int RAW_W      = 12,
    parameter int TRIM_W     = 8,
    parameter int DW         = 32,
    parameter int UNCAL_GAIN = 1000,
    localparam int CH_W      = $clog2(NCH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cal_valid,
    input  logic [CH_W-1:0]          cal_ch,
    input  logic signed [TRIM_W-1:0] cal_lo_trim,
    input  logic signed [TRIM_W-1:0] cal_hi_trim,
    output logic                     cal_done,
    input  logic                     conv_valid,
    input  logic [CH_W-1:0]          conv_ch,
    input  logic [RAW_W-1:0]         conv_raw,
    output logic                     busy,
    output logic                     out_valid,
    output logic signed [DW-1:0]     out_mv,
    output logic                     out_mismatch,
    output logic                     out_not_cal
);
    import adc_cal_pkg::*;

    localparam logic signed [DW-1:0] K_ONE  = DW'(MILLI);
    localparam logic signed [DW-1:0] X_LO   = DW'(IDEAL_LO);
    localparam logic signed [DW-1:0] X_SPAN = DW'(IDEAL_HI - IDEAL_LO);
    localparam logic signed [DW-1:0] U_GAIN = DW'(UNCAL_GAIN);

    cal_state_t           state;
    logic [CH_W-1:0]      cur_ch;
    logic signed [DW-1:0] lo_trim_q;
    logic signed [DW-1:0] k_q;

    logic                 dv_start, dv_running, dv_done;
    logic signed [DW-1:0] dv_num, dv_den, dv_quo;

    logic                 st_we;
    logic signed [DW-1:0] st_off;
    logic [CH_W-1:0]      rd_ch;
    logic signed [DW-1:0] rd_k, rd_gain, rd_off;
    logic                 rd_ok, rd_uncal;

    logic                 cal_uncal;
    logic signed [DW-1:0] raw_s;
    logic signed [DW-1:0] v_span;

    assign busy      = (state != ST_IDLE);
    assign cal_uncal = chan_uncal(int'(cal_ch));
    assign raw_s     = signed'(DW'(conv_raw));
    assign v_span    = DW'(chan_v_hi(int'(cur_ch)) - chan_v_lo(int'(cur_ch)));
    assign rd_ch     = (state == ST_IDLE) ? conv_ch : cur_ch;
    assign st_we     = (state == ST_GAIN) && dv_done;
    assign st_off    = lo_trim_q * K_ONE - (k_q - K_ONE) * X_LO;

    adc_seq_div #(.DW(DW)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (dv_start),
        .num     (dv_num),
        .den     (dv_den),
        .running (dv_running),
        .done    (dv_done),
        .quo     (dv_quo)
    );

    adc_cal_store #(.NCH(NCH), .DW(DW), .CH_W(CH_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (st_we),
        .wr_ch    (cur_ch),
        .wr_k     (k_q),
        .wr_gain  (dv_quo),
        .wr_off   (st_off),
        .rd_ch    (rd_ch),
        .rd_k     (rd_k),
        .rd_gain  (rd_gain),
        .rd_off   (rd_off),
        .rd_ok    (rd_ok),
        .rd_uncal (rd_uncal)
    );

    // Choose the next division and its operands for the current step.
    always_comb begin
        dv_start = 1'b0;
        dv_num   = '0;
        dv_den   = K_ONE;
        case (state)
            ST_IDLE: begin
                if (cal_valid) begin
                    if (!cal_uncal) begin
                        dv_start = 1'b1;
                        dv_num   = K_ONE * (DW'(cal_hi_trim) - DW'(cal_lo_trim));
                        dv_den   = X_SPAN;
                    end
                end else if (conv_valid) begin
                    if (rd_uncal) begin
                        dv_start = 1'b1;
                        dv_num   = raw_s * U_GAIN;
                        dv_den   = K_ONE;
                    end else if (rd_ok) begin
                        dv_start = 1'b1;
                        dv_num   = raw_s * K_ONE - rd_off;
                        dv_den   = rd_k;
                    end
                end
            end
            ST_GERR: begin
                if (dv_done) begin
                    dv_start = 1'b1;
                    dv_num   = v_span * K_ONE;
                    dv_den   = X_SPAN;
                end
            end
            ST_INTER: begin
                if (dv_done && !dv_quo[DW-1]) begin
                    dv_start = 1'b1;
                    dv_num   = dv_quo * rd_gain;
                    dv_den   = K_ONE;
                end
            end
            default: ;
        endcase
    end

    // Sequence requests through the divider and register results and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            cur_ch       <= '0;
            lo_trim_q    <= '0;
            k_q          <= '0;
            cal_done     <= 1'b0;
            out_valid    <= 1'b0;
            out_mv       <= '0;
            out_mismatch <= 1'b0;
            out_not_cal  <= 1'b0;
        end else begin
            cal_done  <= 1'b0;
            out_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (cal_valid) begin
                        cur_ch <= cal_ch;
                        if (cal_uncal) begin
                            cal_done <= 1'b1;
                        end else begin
                            lo_trim_q <= DW'(cal_lo_trim);
                            state     <= ST_GERR;
                        end
                    end else if (conv_valid) begin
                        cur_ch <= conv_ch;
                        if (rd_uncal) begin
                            state <= ST_SCALE;
                        end else if (rd_ok) begin
                            state <= ST_INTER;
                        end else begin
                            out_valid    <= 1'b1;
                            out_mv       <= raw_s;
                            out_mismatch <= 1'b0;
                            out_not_cal  <= 1'b1;
                        end
                    end
                end
                ST_GERR: begin
                    if (dv_done) begin
                        k_q   <= K_ONE + dv_quo;
                        state <= ST_GAIN;
                    end
                end
                ST_GAIN: begin
                    if (dv_done) begin
                        cal_done <= 1'b1;
                        state    <= ST_IDLE;
                    end
                end
                ST_INTER: begin
                    if (dv_done) begin
                        if (dv_quo[DW-1]) begin
                            out_valid    <= 1'b1;
                            out_mv       <= '0;
                            out_mismatch <= 1'b1;
                            out_not_cal  <= 1'b0;
                            state        <= ST_IDLE;
                        end else begin
                            state <= ST_SCALE;
                        end
                    end
                end
                ST_SCALE: begin
                    if (dv_done) begin
                        out_valid    <= 1'b1;
                        out_mv       <= dv_quo;
                        out_mismatch <= 1'b0;
                        out_not_cal  <= 1'b0;
                        state        <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R7: a result is never delivered while the block still reports busy
    a_r7_idle_on_result: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid || cal_done) |-> !busy);
    // R7: conversion and calibration results never coincide
    a_r7_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && cal_done));
    // R8: busy only rises on an accepted request
    a_r8_rise_on_request: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cal_valid || conv_valid));
    // R4: a mismatch result always carries zero
    a_r4_mismatch_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_mismatch) |-> (out_mv == '0));
    // R6: the not-calibrated answer comes straight from an idle acceptance
    a_r6_notcal_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_not_cal) |-> ($past(conv_valid) && !out_mismatch));
    // R9: the divider only runs while an operation is in flight
    a_r9_div_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        dv_running |-> busy);

endmodule

// File: tb/adc_cal_corrector_test.sv
`timescale 1ns/1ps
module adc_cal_corrector_test;

    localparam int DW = 32;
    localparam int NV = 12;
    // Vector table: {channel[15:12], raw[11:0]}
    localparam logic [15:0] VEC [NV] = '{
        {4'd0,  12'd2064}, {4'd0,  12'd3112}, {4'd0,  12'd4095},
        {4'd2,  12'd0},    {4'd9,  12'd1000}, {4'd14, 12'd0},
        {4'd14, 12'd4095}, {4'd6,  12'd2500}, {4'd11, 12'd4095},
        {4'd15, 12'd7},    {4'd13, 12'd0},    {4'd6,  12'd1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cal_valid = 1'b0;
    logic [3:0] cal_ch = '0;
    logic signed [7:0] cal_lo_trim = '0;
    logic signed [7:0] cal_hi_trim = '0;
    logic cal_done;
    logic conv_valid = 1'b0;
    logic [3:0] conv_ch = '0;
    logic [11:0] conv_raw = '0;
    logic busy, out_valid, out_mismatch, out_not_cal;
    logic signed [31:0] out_mv;

    int errors = 0;
    int checks = 0;
    int m_d1 [16];
    int m_d2 [16];
    bit m_cal [16];

    always #4 clk = ~clk;

    adc_cal_corrector uut (
        .clk(clk), .rst_n(rst_n),
        .cal_valid(cal_valid), .cal_ch(cal_ch),
        .cal_lo_trim(cal_lo_trim), .cal_hi_trim(cal_hi_trim), .cal_done(cal_done),
        .conv_valid(conv_valid), .conv_ch(conv_ch), .conv_raw(conv_raw),
        .busy(busy), .out_valid(out_valid), .out_mv(out_mv),
        .out_mismatch(out_mismatch), .out_not_cal(out_not_cal)
    );

    function automatic bit is_free(input int ch);
        return ch == 11 || ch == 12 || ch == 13 || ch == 15;
    endfunction

    function automatic int vlo(input int ch);
        case (ch)
            2: return 1260; 6, 7: return 2520; 8: return 3150; 9: return 5670;
            10: return 3465; 14: return 3645; default: return 630;
        endcase
    endfunction

    function automatic int vhi(input int ch);
        case (ch)
            2: return 1900; 6, 7: return 3800; 8: return 4750; 9: return 8550;
            10, 14: return 5225; default: return 950;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected result from the requirement formulas.
    task automatic model(input int ch, input int raw, output int v, output bit mis,
                         output bit nc, output int lat, output string tag);
        int k, g, off, i;
        mis = 0; nc = 0;
        if (is_free(ch)) begin
            v = raw * 1000 / 1000; lat = DW + 2; tag = "R5";
        end else if (!m_cal[ch]) begin
            v = raw; nc = 1; lat = 1; tag = "R6";
        end else begin
            k   = 1000 + 1000 * (m_d2[ch] - m_d1[ch]) / 1048;
            g   = (vhi(ch) - vlo(ch)) * 1000 / 1048;
            off = m_d1[ch] * 1000 - (k - 1000) * 2064;
            i   = (raw * 1000 - off) / k;
            if (i < 0) begin
                v = 0; mis = 1; lat = DW + 2; tag = "R4";
            end else begin
                v = i * g / 1000; lat = 2 * DW + 3; tag = "R3";
            end
        end
    endtask

    task automatic do_cal(input int ch, input int lo, input int hi, input bit with_conv);
        int edges, lat;
        bit saw_out;
        lat = is_free(ch) ? 1 : 2 * DW + 3;
        @(negedge clk);
        cal_valid = 1; cal_ch = 4'(ch); cal_lo_trim = 8'(lo); cal_hi_trim = 8'(hi);
        if (with_conv) begin conv_valid = 1; conv_ch = 4'd3; conv_raw = 12'd55; end
        @(posedge clk); edges = 1;
        @(negedge clk); cal_valid = 0; conv_valid = 0;
        saw_out = out_valid;
        while (!cal_done && edges < 1000) begin
            @(posedge clk); edges++;
            @(negedge clk);
            saw_out |= out_valid;
        end
        check(edges == lat, is_free(ch) ? "R5" : "R9", "calibration latency", edges, lat);
        if (with_conv) check(!saw_out, "R7", "dropped conversion produced a result", 1, 0);
        if (!is_free(ch)) begin m_d1[ch] = lo; m_d2[ch] = hi; m_cal[ch] = 1; end
    endtask

    task automatic do_conv(input int ch, input int raw, input bit poke);
        int ev, el, edges;
        bit em, en, seen_busy, extra;
        string tag;
        model(ch, raw, ev, em, en, el, tag);
        @(negedge clk);
        conv_valid = 1; conv_ch = 4'(ch); conv_raw = 12'(raw);
        @(posedge clk); edges = 1;
        @(negedge clk); conv_valid = 0;
        seen_busy = busy;
        while (!out_valid && edges < 1000) begin
            if (poke && edges == 5) begin
                cal_valid = 1; cal_ch = 4'(ch); cal_lo_trim = -8'sd77; cal_hi_trim = 8'sd99;
                conv_valid = 1; conv_ch = 4'd1;
            end
            @(posedge clk); edges++;
            @(negedge clk); cal_valid = 0; conv_valid = 0;
        end
        check(out_mv == ev, tag, "value", out_mv, ev);
        check(out_mismatch == em, "R4", "mismatch flag", int'(out_mismatch), int'(em));
        check(out_not_cal == en, "R6", "not-calibrated flag", int'(out_not_cal), int'(en));
        check(edges == el, "R9", "conversion latency", edges, el);
        if (el > 1) check(seen_busy, "R7", "busy during operation", int'(seen_busy), 1);
        else        check(!seen_busy, "R6", "busy on direct path", int'(seen_busy), 0);
        if (poke) begin
            extra = 0;
            repeat (3 * DW) begin @(negedge clk); extra |= out_valid | cal_done; end
            check(!extra, "R8", "result from request while busy", int'(extra), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < 16; c++) begin m_cal[c] = 0; m_d1[c] = 0; m_d2[c] = 0; end
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !out_valid && !cal_done, "R1", "outputs after reset",
              int'({busy, out_valid, cal_done}), 0);
        rst_n = 1;
        @(negedge clk);
        check(!busy, "R1", "busy after release", int'(busy), 0);

        // R6: conversion before any calibration
        do_conv(0, 1234, 0);
        do_conv(9, 4095, 0);

        // R7 and R10: calibration wins over a simultaneous conversion; d1=5,d2=-3 gives k=993
        do_cal(0, 5, -3, 1);
        do_cal(2, -10, 20, 0);
        do_cal(9, 0, 0, 0);
        do_cal(14, 127, -128, 0);
        do_cal(6, -128, 127, 0);

        // R3/R4/R5: vector table
        for (int i = 0; i < NV; i++) do_conv(int'(VEC[i][15:12]), int'(VEC[i][11:0]), 0);

        // R8: requests while busy change nothing
        do_conv(9, 3000, 1);
        do_conv(9, 3000, 0);

        // R5: calibration on a channel without trims is a no-op with an immediate done
        do_cal(12, 50, -50, 0);
        do_conv(12, 100, 0);

        // R2: recalibration replaces coefficients
        do_cal(0, -40, 60, 0);
        do_conv(0, 2064, 0);
        do_conv(0, 0, 0);

        // R6: channel still uncalibrated after others were
        do_conv(10, 777, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule